// File: doc/BRIEF.md
# Bridge Fault Protection Supervisor

This block sits between a set of digital comparator flags and the gate controller of a four-switch H-bridge. It turns the flags into one force-off request and a small set of status outputs. Three conditions are hard faults: over-temperature, a short circuit, and peak overcurrent on the high side. Any of them shuts the bridge down and sets a latched fault. A fourth condition is a programmable current limit. It only turns the bridge off for the rest of the present switching period and needs no recovery action. A strobe from the pulse-width generator marks the start of each new period.

Current spikes follow each gate transition, so the current-limit flag is masked for a programmable number of clock cycles after each transition that the gate controller reports. A latched fault is released only by a disable pulse: the disable input goes high, then low. The latch comes out of reset in the set state, so the bridge stays off until software gives the first disable pulse. A configuration input can switch off thermal protection. All inputs are synchronous to the block clock, and every output responds one clock after the inputs that cause it.

Top module: `bridge_guard`

## Requirements
- R1: After synchronous reset, fault_latched=1, force_off=1, sc_status=0, tlim_status=0 and climit_active=0.
- R2: While disable_in is high, force_off is 1 one cycle later. A high-to-low transition of disable_in clears fault_latched, and force_off drops in the cycle after the low sample when no other cause is present.
- R3: A peak overcurrent flag sets fault_latched and force_off on the next cycle. Both stay set after the flag goes away.
- R4: A short-circuit flag sets fault_latched on the next cycle. sc_status follows the flag with one cycle of delay and does not latch.
- R5: With thermal_en=1, an over-temperature flag sets fault_latched on the next cycle. tlim_status follows the flag with one cycle of delay and does not latch.
- R6: With thermal_en=0, an over-temperature flag has no effect: fault_latched, tlim_status and force_off stay 0.
- R7: A current-limit flag outside the blanking window sets climit_active and force_off on the next cycle without setting fault_latched. Both stay set until cycle_start is sampled, and both clear one cycle later.
- R8: The current-limit flag is ignored in the cycle where gate_edge is high and in the BLANK_CYCLES cycles after it (default 4). It takes effect again in the next cycle.
- R9: If a fault flag is present in the cycle where disable_in returns low, fault_latched stays set.
- R10: When the current-limit flag and cycle_start arrive in the same cycle, the limit takes priority and climit_active is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ot_flag | input | 1 | Over-temperature comparator flag |
| sc_flag | input | 1 | Short-circuit comparator flag |
| oc_flag | input | 1 | Peak overcurrent comparator flag |
| ilim_flag | input | 1 | Programmable current-limit comparator flag |
| thermal_en | input | 1 | 1 enables the over-temperature shutdown |
| disable_in | input | 1 | Forces the bridge off; a high-then-low pulse releases the fault latch |
| cycle_start | input | 1 | Strobe that marks the start of a switching period |
| gate_edge | input | 1 | Gate transition reported by the gate controller |
| force_off | output | 1 | Request to turn all four switches off |
| fault_latched | output | 1 | Latched fault status |
| sc_status | output | 1 | Short-circuit status, not latched |
| tlim_status | output | 1 | Over-temperature status, not latched |
| climit_active | output | 1 | Current-limit off period in progress |

## Verification
The stimulus applies each hard-fault flag on its own and shows that the fault latch holds after the flag is gone while the matching status flag drops. This separates the latched outputs from the unlatched ones. The same over-temperature pulse is applied with thermal protection on and then off, which shows that the enable gates both the shutdown and the status flag. The current-limit flag is held high across a gate transition. This marks the exact cycle at which blanking ends, and shows that the limit ends on the cycle strobe and never reaches the fault latch. Two further patterns resolve the ordering cases: a fault flag present at the falling edge of disable, and a current-limit flag that arrives together with the cycle strobe.

// File: rtl/bridge_guard_pkg.sv
package bridge_guard_pkg;

    // Comparator inputs, gathered into one bundle
    typedef struct packed {
        logic over_temp;
        logic short_ckt;
        logic peak_oc;
        logic cur_lim;
    } cmp_flags_t;

    // Status bundle driven to the outputs
    typedef struct packed {
        logic force_off;
        logic fault;
        logic sc;
        logic tlim;
        logic climit;
    } guard_status_t;

    // Conditions that set the latched shutdown
    function automatic logic hard_trip(input cmp_flags_t f, input logic therm_en);
        return f.short_ckt | f.peak_oc | (f.over_temp & therm_en);
    endfunction

endpackage

// File: rtl/bg_blank_timer.sv
module bg_blank_timer #(
    parameter int BLANK_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_edge,
    output logic blanked
);
    localparam int CW = (BLANK_CYCLES < 1) ? 1 : $clog2(BLANK_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(BLANK_CYCLES);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (gate_edge) begin
            remain_q <= LOAD;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // The transition cycle itself is also masked
    assign blanked = gate_edge | (remain_q != '0);
endmodule

// File: rtl/bg_cycle_limit.sv
module bg_cycle_limit (
    input  logic clk,
    input  logic rst,
    input  logic ilim_raw,
    input  logic blanked,
    input  logic cycle_start,
    output logic climit
);
    logic qualified;
    logic climit_q;

    assign qualified = ilim_raw & ~blanked;

    always_ff @(posedge clk) begin
        if (rst) begin
            climit_q <= 1'b0;
        end else if (qualified) begin
            climit_q <= 1'b1;
        end else if (cycle_start) begin
            climit_q <= 1'b0;
        end
    end

    assign climit = climit_q;
endmodule

// File: rtl/bg_fault_latch.sv
module bg_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic trip,
    input  logic disable_in,
    output logic fault,
    output logic dis_held
);
    logic fault_q;
    logic dis_q;
    logic release_ev;

    assign release_ev = dis_q & ~disable_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b1;
            dis_q   <= 1'b0;
        end else begin
            dis_q <= disable_in;
            if (release_ev) begin
                fault_q <= trip;
            end else if (trip) begin
                fault_q <= 1'b1;
            end
        end
    end

    assign fault    = fault_q;
    assign dis_held = dis_q;
endmodule

// File: rtl/bridge_guard.sv
module bridge_guard
    import bridge_guard_pkg::*;
#(
    parameter int BLANK_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ot_flag,
    input  logic sc_flag,
    input  logic oc_flag,
    input  logic ilim_flag,
    input  logic thermal_en,
    input  logic disable_in,
    input  logic cycle_start,
    input  logic gate_edge,
    output logic force_off,
    output logic fault_latched,
    output logic sc_status,
    output logic tlim_status,
    output logic climit_active
);
    cmp_flags_t    flags;
    guard_status_t st;
    logic          trip;
    logic          blanked;
    logic          fault_w;
    logic          dis_held;
    logic          climit_w;
    logic          sc_q;
    logic          tlim_q;

    assign flags = '{over_temp: ot_flag, short_ckt: sc_flag,
                     peak_oc: oc_flag, cur_lim: ilim_flag};
    assign trip  = hard_trip(flags, thermal_en);

    bg_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
        .clk       (clk),
        .rst       (rst),
        .gate_edge (gate_edge),
        .blanked   (blanked)
    );

    bg_cycle_limit u_limit (
        .clk         (clk),
        .rst         (rst),
        .ilim_raw    (flags.cur_lim),
        .blanked     (blanked),
        .cycle_start (cycle_start),
        .climit      (climit_w)
    );

    bg_fault_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .trip       (trip),
        .disable_in (disable_in),
        .fault      (fault_w),
        .dis_held   (dis_held)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_q   <= 1'b0;
            tlim_q <= 1'b0;
        end else begin
            sc_q   <= flags.short_ckt;
            tlim_q <= flags.over_temp & thermal_en;
        end
    end

    assign st.fault     = fault_w;
    assign st.sc        = sc_q;
    assign st.tlim      = tlim_q;
    assign st.climit    = climit_w;
    assign st.force_off = fault_w | climit_w | dis_held;

    assign force_off     = st.force_off;
    assign fault_latched = st.fault;
    assign sc_status     = st.sc;
    assign tlim_status   = st.tlim;
    assign climit_active = st.climit;
endmodule

// File: rtl/bridge_guard_chk.sv
module bridge_guard_chk (
    input logic clk,
    input logic rst,
    input logic ot_flag,
    input logic sc_flag,
    input logic oc_flag,
    input logic ilim_flag,
    input logic thermal_en,
    input logic disable_in,
    input logic cycle_start,
    input logic gate_edge,
    input logic force_off,
    input logic fault_latched,
    input logic sc_status,
    input logic tlim_status,
    input logic climit_active
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (fault_latched && force_off && !climit_active));

    // R2
    disable_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
        disable_in |=> force_off);

    // R3
    hard_fault_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (oc_flag || sc_flag) |=> (fault_latched && force_off));

    // R4
    sc_follows_chk: assert property (@(posedge clk) disable iff (rst)
        sc_flag |=> sc_status);

    // R4
    sc_unlatched_chk: assert property (@(posedge clk) disable iff (rst)
        !sc_flag |=> !sc_status);

    // R5
    thermal_trip_chk: assert property (@(posedge clk) disable iff (rst)
        (ot_flag && thermal_en) |=> (fault_latched && tlim_status));

    // R6
    thermal_off_chk: assert property (@(posedge clk) disable iff (rst)
        !thermal_en |=> !tlim_status);

    // R7
    limit_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (climit_active && !cycle_start) |=> climit_active);

    // R7
    limit_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
        climit_active |-> force_off);

    // R8
    blank_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_edge && !climit_active) |=> !climit_active);

    // R10
    limit_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (ilim_flag && cycle_start && !gate_edge && !climit_active && !$past(gate_edge))
            |=> (climit_active || $past(climit_active)));
endmodule

bind bridge_guard bridge_guard_chk u_chk (.*);

// File: tb/bridge_guard_tb_top.sv
module bridge_guard_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ot_flag = 0, sc_flag = 0, oc_flag = 0, ilim_flag = 0;
    logic thermal_en = 1, disable_in = 0, cycle_start = 0, gate_edge = 0;
    logic force_off, fault_latched, sc_status, tlim_status, climit_active;

    // input vector bits: {ot, sc, oc, il, ten, dis, cs, ge}
    localparam bit [7:0] OT  = 8'h80;
    localparam bit [7:0] SC  = 8'h40;
    localparam bit [7:0] OC  = 8'h20;
    localparam bit [7:0] IL  = 8'h10;
    localparam bit [7:0] TEN = 8'h08;
    localparam bit [7:0] DIS = 8'h04;
    localparam bit [7:0] CS  = 8'h02;
    localparam bit [7:0] GE  = 8'h01;

    int n_checks = 0;
    int n_fail   = 0;
    bit [4:0] exp_q[$];
    string    tag_q[$];
    bit       done = 0;

    always #10 clk = ~clk;

    bridge_guard dut_i (
        .clk(clk), .rst(rst), .ot_flag(ot_flag), .sc_flag(sc_flag),
        .oc_flag(oc_flag), .ilim_flag(ilim_flag), .thermal_en(thermal_en),
        .disable_in(disable_in), .cycle_start(cycle_start), .gate_edge(gate_edge),
        .force_off(force_off), .fault_latched(fault_latched), .sc_status(sc_status),
        .tlim_status(tlim_status), .climit_active(climit_active)
    );

    // Driver: expected value {force_off, fault, sc, tlim, climit} after the next edge
    task automatic drive(input bit [7:0] v, input bit [4:0] exp, input string tag);
        @(negedge clk);
        {ot_flag, sc_flag, oc_flag, ilim_flag, thermal_en, disable_in, cycle_start, gate_edge} = v;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                bit [4:0] e;
                bit [4:0] a;
                string    t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {force_off, fault_latched, sc_status, tlim_status, climit_active};
                n_checks++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: got %b expected %b", t, a, e);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive(TEN, 5'b11000, "R1");
        drive(TEN | DIS, 5'b11000, "R2");
        drive(TEN, 5'b00000, "R2");
        drive(TEN, 5'b00000, "R2");
        drive(TEN | OC, 5'b11000, "R3");
        drive(TEN, 5'b11000, "R3");
        drive(TEN | DIS, 5'b11000, "R2");
        drive(TEN, 5'b00000, "R2");
        drive(TEN | SC, 5'b11100, "R4");
        drive(TEN, 5'b11000, "R4");
        drive(TEN | DIS, 5'b11000, "R2");
        drive(TEN, 5'b00000, "R2");
        drive(TEN | OT, 5'b11010, "R5");
        drive(TEN, 5'b11000, "R5");
        drive(TEN | DIS, 5'b11000, "R2");
        drive(TEN, 5'b00000, "R2");
        drive(OT, 5'b00000, "R6");
        drive(OT, 5'b00000, "R6");
        drive(TEN, 5'b00000, "R6");
        drive(TEN | IL, 5'b10001, "R7");
        drive(TEN, 5'b10001, "R7");
        drive(TEN | CS, 5'b00000, "R7");
        drive(TEN | GE | IL, 5'b00000, "R8");
        for (int i = 0; i < 4; i++) drive(TEN | IL, 5'b00000, "R8");
        drive(TEN | IL, 5'b10001, "R8");
        drive(TEN | CS, 5'b00000, "R7");
        drive(TEN | IL | CS, 5'b10001, "R10");
        drive(TEN | CS, 5'b00000, "R10");
        drive(TEN | DIS, 5'b10000, "R2");
        drive(TEN | DIS | OC, 5'b11000, "R9");
        drive(TEN | OC, 5'b11000, "R9");
        drive(TEN, 5'b11000, "R9");
        drive(TEN | DIS, 5'b11000, "R2");
        drive(TEN, 5'b00000, "R2");
        repeat (3) @(negedge clk);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule